// File: doc/BRIEF.md
# Contrast Pulse-Width Modulator

This block produces a single pulse-width-modulated output for setting display contrast. An external RC filter turns the output into an analog level. An 8-bit counter runs freely and advances only on cycles where the prescale enable input is high, so one period lasts 256 enabled cycles. A compare value and a polarity bit come from write ports driven by software.

While the counter is strictly below the compare value, the output takes the polarity bit. For every other count it takes the inverse of the polarity bit. A new compare value waits in a shadow register and is copied into the active compare at the counter wrap, so a period never mixes two settings. A polarity write takes effect on the next clock.

Top module: `contrast_pwm`

## Requirements
- R1: After the active-low asynchronous reset, the counter, the shadow and active compare values, and the polarity bit are all zero, so `pwm_o` is 1.
- R2: The counter advances by one, modulo 256, on each clock where `tick_i` is 1. It holds its value when `tick_i` is 0.
- R3: `pwm_o` equals the polarity bit while the counter is strictly less than the active compare value. Otherwise `pwm_o` equals the inverted polarity bit.
- R4: A write through `level_we_i` changes the shadow value at once. The active compare value is loaded only on a clock where `tick_i` is 1 and the counter is 255. A write on that same clock is the value loaded.
- R5: A write through `pol_we_i` sets the polarity bit on that clock edge, so the new polarity applies from the next cycle.
- R6: With an active compare of 0, `pwm_o` stays at the inverted polarity for the whole period (a pulse width of 0). With an active compare of 255, the pulse lasts 255 of the 256 counts.
- R7: Over one full period with `tick_i` held at 1, `pwm_o` is 1 for exactly C counts when polarity is 1, and for 256−C counts when polarity is 0, where C is the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescale enable for the counter |
| level_we_i | input | 1 | Write strobe for the compare value |
| level_i | input | 8 | Compare value to write |
| pol_we_i | input | 1 | Write strobe for the polarity bit |
| pol_i | input | 1 | Polarity value to write |
| pwm_o | output | 1 | Contrast PWM output |

## Verification
The hardest case to reach is a compare write that lands exactly on the wrap clock, while the enable is also high. Only then does a write bypass the shadow and take effect in the new period. Random stimulus rarely hits that exact cycle, so the random phase keeps the enable high most of the time and writes often. The directed phase also issues writes while the counter stands at 255 with the enable toggling. Full-period counts at compare values 0, 255 and a middle value confirm the duty extremes under both polarities.

// File: rtl/contrast_pwm_pkg.sv
package contrast_pwm_pkg;
  localparam int unsigned PWM_W = 8;
  typedef logic [PWM_W-1:0] pwm_val_t;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CntMax = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i && (cnt_q == CntMax);
endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  input  logic         load_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] shadow_q, act_q, shadow_nxt;

  // a write on the wrap clock goes straight into the new period
  assign shadow_nxt = we_i ? d_i : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (load_i) act_q <= shadow_nxt;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] act_i,
  input  logic         pol_i,
  output logic         out_o
);
  assign out_o = (cnt_i < act_i) ? pol_i : ~pol_i;
endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm
  import contrast_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     level_we_i,
  input  pwm_val_t level_i,
  input  logic     pol_we_i,
  input  logic     pol_i,
  output logic     pwm_o
);
  pwm_val_t cnt_q;
  pwm_val_t cmp_act;
  logic     wrap;
  logic     pol_q;

  pwm_counter #(.W(PWM_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_i),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  pwm_shadow_reg #(.W(PWM_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (level_we_i),
    .d_i    (level_i),
    .load_i (wrap),
    .act_o  (cmp_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= 1'b0;
    else if (pol_we_i) pol_q <= pol_i;
  end

  pwm_compare #(.W(PWM_W)) u_cmpr (
    .cnt_i (cnt_q),
    .act_i (cmp_act),
    .pol_i (pol_q),
    .out_o (pwm_o)
  );
endmodule

// File: rtl/contrast_pwm_chk.sv
module contrast_pwm_chk
  import contrast_pwm_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     tick_i,
  input logic     pol_we_i,
  input logic     pol_i,
  input pwm_val_t cnt,
  input pwm_val_t act,
  input logic     pol,
  input logic     pwm_o
);
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt == pwm_val_t'($past(cnt) + 1'b1));

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt));

  assert_act_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && cnt == {PWM_W{1'b1}}) |=> $stable(act));

  assert_pol_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_we_i |=> pol == $past(pol_i));

  assert_out_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == {PWM_W{1'b1}} |-> pwm_o == ~pol);

  assert_out_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && act != '0) |-> pwm_o == pol);
endmodule

bind contrast_pwm contrast_pwm_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .pol_we_i (pol_we_i),
  .pol_i    (pol_i),
  .cnt      (cnt_q),
  .act      (cmp_act),
  .pol      (pol_q),
  .pwm_o    (pwm_o)
);

// File: tb/contrast_pwm_test.sv
`timescale 1ns/1ps
module contrast_pwm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, lvl_we = 1'b0, pol_we = 1'b0, pol_in = 1'b0;
  logic [7:0] lvl = 8'd0;
  logic       pwm;

  int checks = 0, fails = 0;
  bit done = 1'b0, run_chk = 1'b0;

  // reference state, built from the requirements
  logic [7:0] m_cnt, m_pend, m_act;
  logic       m_pol, last_tick, last_polwe;

  always #2.5 clk = ~clk;

  contrast_pwm uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .level_we_i(lvl_we),
    .level_i(lvl), .pol_we_i(pol_we), .pol_i(pol_in), .pwm_o(pwm)
  );

  function automatic logic exp_out(logic [7:0] c, logic [7:0] a, logic p);
    return (c < a) ? p : ~p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_pend <= 0; m_act <= 0; m_pol <= 0;
      last_tick <= 0; last_polwe <= 0;
    end else begin
      if (tick) m_cnt <= m_cnt + 8'd1;
      if (tick && m_cnt == 8'hFF) m_act <= lvl_we ? lvl : m_pend;
      if (lvl_we) m_pend <= lvl;
      if (pol_we) m_pol <= pol_in;
      last_tick <= tick;
      last_polwe <= pol_we;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pwm_o=%0b expected %0b (cnt=%0d cmp=%0d pol=%0b)",
               tag, act, exp, m_cnt, m_act, m_pol);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      string tag;
      if (last_polwe)                       tag = "R5";
      else if (m_pend != m_act)             tag = "R4";
      else if (!last_tick)                  tag = "R2";
      else if (m_act == 0 || m_act == 255)  tag = "R6";
      else                                  tag = "R3";
      check(tag, pwm, exp_out(m_cnt, m_act, m_pol));
    end
  end

  task automatic duty(logic [7:0] c, logic p);
    int hi = 0;
    int exp;
    @(negedge clk);
    tick <= 1; lvl_we <= 1; lvl <= c; pol_we <= 1; pol_in <= p;
    @(negedge clk);
    lvl_we <= 0; pol_we <= 0;
    while (!(m_cnt == 0 && m_act == c)) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      hi += int'(pwm);
      @(negedge clk);
    end
    exp = p ? int'(c) : 256 - int'(c);
    checks++;
    if (hi != exp) begin
      fails++;
      $display("FAIL R7: high count=%0d expected %0d (cmp=%0d pol=%0b)", hi, exp, c, p);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    #12;
    checks++;
    if (pwm !== 1'b1) begin
      fails++;
      $display("FAIL R1: pwm_o=%0b expected 1 in reset", pwm);
    end
    @(negedge clk); rst_n <= 1;
    run_chk = 1'b1;
    @(negedge clk);
    check("R1", pwm, 1'b1);

    // R2: stalled counter, then step
    repeat (20) @(negedge clk);
    // R7/R6 directed extremes
    duty(8'd0, 1'b1);
    duty(8'd255, 1'b1);
    duty(8'd0, 1'b0);
    duty(8'd255, 1'b0);
    duty(8'd100, 1'b1);
    duty(8'd100, 1'b0);

    // R4: writes timed at the wrap with enable toggling
    for (int k = 0; k < 8; k++) begin
      while (m_cnt != 8'hFF) begin
        tick <= 1; @(negedge clk);
      end
      tick <= 0; @(negedge clk);
      tick <= k[0]; lvl_we <= 1; lvl <= 8'($urandom);
      @(negedge clk);
      lvl_we <= 0; tick <= 1;
      repeat (3) @(negedge clk);
    end

    // random phase
    for (int n = 0; n < 8000; n++) begin
      tick   <= ($urandom % 4) != 0;
      lvl_we <= ($urandom % 6) == 0;
      case ($urandom % 4)
        0: lvl <= 8'd0;
        1: lvl <= 8'd255;
        default: lvl <= 8'($urandom);
      endcase
      pol_we <= ($urandom % 24) == 0;
      pol_in <= 1'($urandom);
      @(negedge clk);
    end
    tick <= 0; lvl_we <= 0; pol_we <= 0;
    @(negedge clk);
    run_chk = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule